// File: doc/BRIEF.md
# Random Word Generator Command and Status Port

This block is the register front end of a random number source. A host talks to it through a single-cycle register port. It writes 32-bit command words into a control register and reads an 8-bit state code from a status register. When the state code says a word is ready, it reads a 32-bit random word. The block walks the host through a fixed bring-up: it acknowledges a reset, waits for release and enable, and then on a zeroize command reseeds its generator and runs a startup self-test. After the host acknowledges the test result, words are handed out one at a time. Each word must be consumed and acknowledged, and generation of the next one then re-armed, before that next word appears.

A Galois linear-feedback shift register stands in for the entropy source. A stuck-value check on its first samples after zeroize stands in for health testing. The reset wait and the length of the self-test are parameters in clock cycles, so a bench can shorten them.

The controller has these states:
- IDLE: after the reset pin, status 0x00.
- RSTWAIT: counting the reset delay, status 0x00.
- RSTACK: reset acknowledged, status 0xAC.
- RELEASED: status 0xAC.
- ENABLED: status 0xAC.
- SELFTEST: sampling, status 0x00.
- TESTOK: status 0x57.
- TESTFAIL: status 0xFA.
- GEN: latching a word, status 0x00.
- AVAIL: word ready, status 0xED.
- CONSUMED: word acknowledged, status 0x00.

The transitions are:
- Reset command: any state to RSTWAIT.
- Delay expiry: RSTWAIT to RSTACK.
- Release: RSTACK to RELEASED.
- Enable: RELEASED to ENABLED.
- Zeroize: ENABLED to SELFTEST.
- Test done: SELFTEST to TESTOK or TESTFAIL.
- Zeroize acknowledge: TESTOK to GEN.
- Latch: GEN to AVAIL.
- Read acknowledge: AVAIL to CONSUMED.
- Enable: CONSUMED to GEN.

Top module: `trng_host_if`

## Requirements
- R1: While the reset pin is high and after it is released, the status code reads 0x00 and a read at offset 0x0 returns zero.
- R2: A write acts only at byte offset 0x0. A read at offset 0x4 returns the status code in bits 7:0 with bits 31:8 zero. A write at offset 0x4, even of a command value, changes nothing.
- R3: Command 0x00000001 (reset) is accepted on a clock edge. The status reads 0x00 until the RST_CYC-th edge after that edge, and from that edge on it reads 0xAC.
- R4: The commands 0x00000002 (release), 0x80000000 (enable) and 0x80000004 (zeroize) act only in that order, after the reset acknowledge. Any command that is not a legal transition for the current state is ignored and the status is unchanged.
- R5: Zeroize reseeds the generator to SEED and clears the held word. The self-test then takes TEST_SAMPLES cycles, with status 0x00, and the status reads 0x57 on the following edge when no sample failed. The generator steps as x' = (x >> 1) ^ (x[0] ? POLY : 0), once per self-test sample and once per word latched.
- R6: The self-test fails if any sample is all zeros or all ones, or equals the sample before it. A failed test reports 0xFA, and only a reset command leaves that state.
- R7: Command 0x80000008 (acknowledge zeroize) at 0x57 starts generation. The status reads 0x00 for one cycle and then 0xED. The first word is the generator value after TEST_SAMPLES steps from SEED.
- R8: A read at offset 0x0 returns the held word while the status is 0xED, and zero otherwise. The held word is stable for as long as 0xED lasts, including the cycle in which the read acknowledge is written.
- R9: Command 0x8000000F (read acknowledge) at 0xED drops the status to 0x00 on the next edge. Enable is ignored at 0xED. A following enable brings 0xED back two edges later with the next generator word.
- R10: A reset command is accepted in every state, including during the self-test and in the failed state, and restarts the sequence of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte offset of the register access |
| we | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 32 | Command word |
| rdata | output | 32 | Read data for the offset on addr, combinational |

## Verification
The consuming read and its acknowledge share offset 0x0, so a host can read the word in the same cycle in which it writes the read-acknowledge command. The bench provokes this by checking rdata while the acknowledge write is on the port. It expects the current word in that cycle and zero once the edge has taken the state to CONSUMED. A second overlap is a reset command arriving while the self-test is still sampling. Reset takes priority over test completion, and the bench confirms this by seeing 0x00 and later 0xAC rather than a test verdict. A copy built with SEED of zero exercises the failing self-test alongside the passing one.

// File: rtl/trng_pkg.sv
package trng_pkg;

    localparam logic [31:0] CMD_RESET   = 32'h0000_0001;
    localparam logic [31:0] CMD_RELEASE = 32'h0000_0002;
    localparam logic [31:0] CMD_ENABLE  = 32'h8000_0000;
    localparam logic [31:0] CMD_ZEROIZE = 32'h8000_0004;
    localparam logic [31:0] CMD_ZACK    = 32'h8000_0008;
    localparam logic [31:0] CMD_RDACK   = 32'h8000_000F;

    localparam logic [7:0] SC_NONE   = 8'h00;
    localparam logic [7:0] SC_RSTACK = 8'hAC;
    localparam logic [7:0] SC_TESTOK = 8'h57;
    localparam logic [7:0] SC_FAIL   = 8'hFA;
    localparam logic [7:0] SC_AVAIL  = 8'hED;

    typedef enum logic [3:0] {
        S_IDLE, S_RSTWAIT, S_RSTACK, S_RELEASED, S_ENABLED, S_SELFTEST,
        S_TESTOK, S_TESTFAIL, S_GEN, S_AVAIL, S_CONSUMED
    } fsm_e;

    typedef enum logic [2:0] {
        C_NONE, C_RESET, C_RELEASE, C_ENABLE, C_ZEROIZE, C_ZACK, C_RDACK
    } cmd_e;

endpackage

// File: rtl/trng_cmd_dec.sv
module trng_cmd_dec
    import trng_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output cmd_e              cmd
);
    always_comb begin
        cmd = C_NONE;
        if (we && addr == '0) begin
            case (wdata)
                CMD_RESET:   cmd = C_RESET;
                CMD_RELEASE: cmd = C_RELEASE;
                CMD_ENABLE:  cmd = C_ENABLE;
                CMD_ZEROIZE: cmd = C_ZEROIZE;
                CMD_ZACK:    cmd = C_ZACK;
                CMD_RDACK:   cmd = C_RDACK;
                default:     cmd = C_NONE;
            endcase
        end
    end
endmodule

// File: rtl/trng_lfsr.sv
module trng_lfsr #(
    parameter int          W    = 32,
    parameter logic [31:0] POLY = 32'h8020_0003,
    parameter logic [31:0] SEED = 32'h1ACE_B00C
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] word
);
    logic [W-1:0] x_q;

    always_ff @(posedge clk) begin
        if (rst || load)
            x_q <= SEED[W-1:0];
        else if (step)
            x_q <= (x_q >> 1) ^ ({W{x_q[0]}} & POLY[W-1:0]);
    end

    assign word = x_q;
endmodule

// File: rtl/trng_selftest.sv
module trng_selftest #(
    parameter int W       = 32,
    parameter int SAMPLES = 1024
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    input  logic [W-1:0] word,
    output logic         done,
    output logic         fail
);
    localparam int SW = $clog2(SAMPLES + 1);

    logic [SW-1:0] cnt_q;
    logic [W-1:0]  prev_q;
    logic          fail_q;
    logic          bad_now;

    always_comb begin
        bad_now = (word == '0) || (word == '1) || (cnt_q != '0 && word == prev_q);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q  <= '0;
            prev_q <= '0;
            fail_q <= 1'b0;
        end else if (run) begin
            cnt_q  <= cnt_q + SW'(1);
            prev_q <= word;
            if (bad_now)
                fail_q <= 1'b1;
        end
    end

    assign done = (cnt_q == SW'(SAMPLES));
    assign fail = fail_q;
endmodule

// File: rtl/trng_ctrl_fsm.sv
module trng_ctrl_fsm
    import trng_pkg::*;
#(
    parameter int RST_CYC = 25000
) (
    input  logic       clk,
    input  logic       rst,
    input  cmd_e       cmd,
    input  logic       test_done,
    input  logic       test_fail,
    output logic [7:0] stat_code,
    output logic       zeroize,
    output logic       test_run,
    output logic       gen,
    output logic       avail
);
    localparam int CW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

    fsm_e          st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q != S_RSTWAIT || cmd == C_RESET)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + CW'(1);
        end
    end

    always_comb begin
        st_d = st_q;
        if (cmd == C_RESET) begin
            st_d = S_RSTWAIT;
        end else begin
            unique case (st_q)
                S_IDLE:     st_d = S_IDLE;
                S_RSTWAIT:  if (cnt_q == CW'(RST_CYC - 1)) st_d = S_RSTACK;
                S_RSTACK:   if (cmd == C_RELEASE) st_d = S_RELEASED;
                S_RELEASED: if (cmd == C_ENABLE)  st_d = S_ENABLED;
                S_ENABLED:  if (cmd == C_ZEROIZE) st_d = S_SELFTEST;
                S_SELFTEST: if (test_done) st_d = test_fail ? S_TESTFAIL : S_TESTOK;
                S_TESTOK:   if (cmd == C_ZACK)    st_d = S_GEN;
                S_TESTFAIL: st_d = S_TESTFAIL;
                S_GEN:      st_d = S_AVAIL;
                S_AVAIL:    if (cmd == C_RDACK)   st_d = S_CONSUMED;
                S_CONSUMED: if (cmd == C_ENABLE)  st_d = S_GEN;
                default:    st_d = S_IDLE;
            endcase
        end
    end

    always_comb begin
        zeroize  = (st_q == S_ENABLED) && (cmd == C_ZEROIZE);
        test_run = (st_q == S_SELFTEST) && !test_done;
        gen      = (st_q == S_GEN);
        avail    = (st_q == S_AVAIL);
        unique case (st_q)
            S_RSTACK, S_RELEASED, S_ENABLED: stat_code = SC_RSTACK;
            S_TESTOK:                        stat_code = SC_TESTOK;
            S_TESTFAIL:                      stat_code = SC_FAIL;
            S_AVAIL:                         stat_code = SC_AVAIL;
            default:                         stat_code = SC_NONE;
        endcase
    end
endmodule

// File: rtl/trng_host_if.sv
module trng_host_if
    import trng_pkg::*;
#(
    parameter int          ADDR_W       = 4,
    parameter int          RST_CYC      = 25000,
    parameter int          TEST_SAMPLES = 1024,
    parameter logic [31:0] POLY         = 32'h8020_0003,
    parameter logic [31:0] SEED         = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4);

    cmd_e        cmd;
    logic [7:0]  stat_code;
    logic        zeroize, test_run, gen, avail, test_done, test_fail;
    logic [31:0] lfsr_word;
    logic [31:0] word_q;

    trng_cmd_dec #(.ADDR_W(ADDR_W)) u_dec (
        .we(we), .addr(addr), .wdata(wdata), .cmd(cmd)
    );

    trng_ctrl_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk(clk), .rst(rst), .cmd(cmd),
        .test_done(test_done), .test_fail(test_fail),
        .stat_code(stat_code), .zeroize(zeroize), .test_run(test_run),
        .gen(gen), .avail(avail)
    );

    trng_lfsr #(.W(32), .POLY(POLY), .SEED(SEED)) u_lfsr (
        .clk(clk), .rst(rst), .load(zeroize), .step(test_run | gen),
        .word(lfsr_word)
    );

    trng_selftest #(.W(32), .SAMPLES(TEST_SAMPLES)) u_test (
        .clk(clk), .rst(rst), .clear(zeroize), .run(test_run),
        .word(lfsr_word), .done(test_done), .fail(test_fail)
    );

    always_ff @(posedge clk) begin
        if (rst || zeroize)
            word_q <= '0;
        else if (gen)
            word_q <= lfsr_word;
    end

    always_comb begin
        rdata = '0;
        if (addr == OFS_DATA)
            rdata = avail ? word_q : '0;
        else if (addr == OFS_STAT)
            rdata = {24'h0, stat_code};
    end
endmodule

// File: rtl/trng_host_if_chk.sv
module trng_host_if_chk
    import trng_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              we,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic [7:0]        stat_code
);
    logic wr0;
    assign wr0 = we && (addr == '0);

    AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(4)) |-> (rdata[31:8] == 24'h0)); // R2

    AST_DATA_GATED: assert property (@(posedge clk) disable iff (rst)
        (addr == '0 && stat_code != SC_AVAIL) |-> (rdata == 32'h0)); // R8

    AST_WORD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (stat_code == SC_AVAIL && $past(stat_code) == SC_AVAIL &&
         addr == '0 && $past(addr) == '0) |-> $stable(rdata)); // R8

    AST_TESTOK_IGNORES_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (stat_code == SC_TESTOK && wr0 && wdata == CMD_ENABLE) |=> (stat_code == SC_TESTOK)); // R4

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_code == SC_FAIL && !(wr0 && wdata == CMD_RESET)) |=> (stat_code == SC_FAIL)); // R6

    AST_RDACK_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (stat_code == SC_AVAIL && wr0 && wdata == CMD_RDACK) |=> (stat_code == SC_NONE)); // R9

    AST_RESET_CMD: assert property (@(posedge clk) disable iff (rst)
        (wr0 && wdata == CMD_RESET) |=> (stat_code == SC_NONE)); // R10
endmodule

bind trng_host_if trng_host_if_chk u_chk (
    .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .stat_code(stat_code)
);

// File: tb/tb_trng_host_if.sv
module tb_trng_host_if;
    localparam int          RST_CYC = 4;
    localparam int          NSAMP   = 8;
    localparam logic [31:0] POLY    = 32'h8020_0003;
    localparam logic [31:0] SEED    = 32'h1ACE_B00C;

    localparam logic [1:0] K_IDLE = 2'd0, K_WR = 2'd1, K_RD = 2'd2;
    localparam logic [31:0] C_RST = 32'h0000_0001, C_REL = 32'h0000_0002,
                            C_EN  = 32'h8000_0000, C_ZER = 32'h8000_0004,
                            C_ZAK = 32'h8000_0008, C_RAK = 32'h8000_000F;

    function automatic logic [31:0] lfsr_word(input int n);
        logic [31:0] x;
        x = SEED;
        for (int i = 0; i < n; i++) x = (x >> 1) ^ ({32{x[0]}} & POLY);
        return x;
    endfunction

    typedef struct packed {
        logic [1:0]  kind;
        logic        chk;
        logic [3:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t TBL [NV] = '{
        '{K_WR, 1'b0, 4'h0, C_RST, 32'h0, 4'd3},
        '{K_IDLE,1'b0,4'h0, 32'(RST_CYC-1), 32'h0, 4'd3},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'h00, 4'd3},        // R3 still waiting
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'hAC, 4'd3},        // R3 acknowledged
        '{K_WR, 1'b0, 4'h0, C_ZER, 32'h0, 4'd4},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'hAC, 4'd4},        // R4 early zeroize ignored
        '{K_WR, 1'b0, 4'h0, C_EN, 32'h0, 4'd4},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'hAC, 4'd4},        // R4 early enable ignored
        '{K_WR, 1'b0, 4'h0, C_REL, 32'h0, 4'd4},
        '{K_WR, 1'b0, 4'h4, C_RST, 32'h0, 4'd2},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'hAC, 4'd2},        // R2 write at 0x4 ignored
        '{K_WR, 1'b0, 4'h0, C_EN, 32'h0, 4'd4},
        '{K_WR, 1'b0, 4'h0, C_REL, 32'h0, 4'd4},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'hAC, 4'd4},        // R4
        '{K_WR, 1'b0, 4'h0, C_ZER, 32'h0, 4'd5},
        '{K_IDLE,1'b0,4'h0, 32'(NSAMP), 32'h0, 4'd5},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'h00, 4'd5},        // R5 testing
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'h57, 4'd5},        // R5 passed
        '{K_RD, 1'b1, 4'h0, 32'h0, 32'h0, 4'd8},         // R8 no word yet
        '{K_WR, 1'b0, 4'h0, C_EN, 32'h0, 4'd4},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'h57, 4'd4},        // R4
        '{K_WR, 1'b0, 4'h0, C_ZAK, 32'h0, 4'd7},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'h00, 4'd7},        // R7 latching
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'hED, 4'd7},        // R7
        '{K_RD, 1'b1, 4'h0, 32'h0, lfsr_word(NSAMP), 4'd7},
        '{K_WR, 1'b0, 4'h0, C_EN, 32'h0, 4'd9},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'hED, 4'd9},        // R9 enable ignored
        '{K_WR, 1'b1, 4'h0, C_RAK, lfsr_word(NSAMP), 4'd8}, // R8 overlap
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'h00, 4'd9},        // R9
        '{K_RD, 1'b1, 4'h0, 32'h0, 32'h0, 4'd8},         // R8
        '{K_WR, 1'b0, 4'h0, C_EN, 32'h0, 4'd9},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'h00, 4'd9},
        '{K_RD, 1'b1, 4'h4, 32'h0, 32'hED, 4'd9},        // R9
        '{K_RD, 1'b1, 4'h0, 32'h0, lfsr_word(NSAMP+1), 4'd9},
        '{K_WR, 1'b0, 4'h0, C_RAK, 32'h0, 4'd9},
        '{K_WR, 1'b0, 4'h0, C_EN, 32'h0, 4'd9},
        '{K_IDLE,1'b0,4'h0, 32'd1, 32'h0, 4'd9},
        '{K_RD, 1'b1, 4'h0, 32'h0, lfsr_word(NSAMP+2), 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_f;
    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    trng_host_if #(.ADDR_W(4), .RST_CYC(RST_CYC), .TEST_SAMPLES(NSAMP),
                   .POLY(POLY), .SEED(SEED)) dut (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata));

    trng_host_if #(.ADDR_W(4), .RST_CYC(RST_CYC), .TEST_SAMPLES(NSAMP),
                   .POLY(POLY), .SEED(32'h0)) dut_f (
        .clk(clk), .rst(rst), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata_f));

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] k, input logic c, input logic [3:0] a,
                      input logic [31:0] d, input logic [31:0] e, input string tag);
        if (k == K_IDLE) begin
            for (int i = 0; i < int'(d); i++) begin
                @(negedge clk); we = 1'b0;
                @(posedge clk);
            end
        end else begin
            @(negedge clk);
            we = (k == K_WR); addr = a; wdata = d;
            #1;
            if (c) check(rdata, e, tag);
            @(posedge clk);
            #1 we = 1'b0;
        end
    endtask

    task automatic chk_f(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1 check(rdata_f, e, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        addr = 4'h4; #1 check(rdata, 32'h00, "R1 status in reset");
        @(negedge clk); rst = 1'b0;
        op(K_RD, 1'b1, 4'h4, 32'h0, 32'h00, "R1 status after reset");
        op(K_RD, 1'b1, 4'h0, 32'h0, 32'h00, "R1 data after reset");

        for (int i = 0; i < NV; i++)
            op(TBL[i].kind, TBL[i].chk, TBL[i].a, TBL[i].d, TBL[i].e,
               $sformatf("R%0d row %0d", TBL[i].rq, i));

        // R6: zero seed fails its self-test and ignored every later command
        chk_f(4'h4, 32'hFA, "R6 zero seed fails and stays");
        chk_f(4'h0, 32'h0, "R8 failed copy gives no data");

        // R10: reset from the available state and from the failed state
        op(K_WR, 1'b0, 4'h0, C_RST, 32'h0, "R10");
        op(K_RD, 1'b1, 4'h4, 32'h0, 32'h00, "R10 reset from available");
        op(K_IDLE, 1'b0, 4'h0, 32'(RST_CYC), 32'h0, "R10");
        chk_f(4'h4, 32'hAC, "R10 failed copy reset acknowledged");
        op(K_RD, 1'b1, 4'h4, 32'h0, 32'hAC, "R10 acknowledged again");

        // R10: reset while the self-test is still sampling
        op(K_WR, 1'b0, 4'h0, C_REL, 32'h0, "R10");
        op(K_WR, 1'b0, 4'h0, C_EN, 32'h0, "R10");
        op(K_WR, 1'b0, 4'h0, C_ZER, 32'h0, "R10");
        op(K_IDLE, 1'b0, 4'h0, 32'd2, 32'h0, "R10");
        op(K_WR, 1'b0, 4'h0, C_RST, 32'h0, "R10");
        op(K_RD, 1'b1, 4'h4, 32'h0, 32'h00, "R10 reset during self-test");
        op(K_IDLE, 1'b0, 4'h0, 32'(RST_CYC - 1), 32'h0, "R10");
        op(K_RD, 1'b1, 4'h4, 32'h0, 32'hAC, "R10 acknowledged after abort");

        // R5: a fresh zeroize reseeds, so the first word repeats
        op(K_WR, 1'b0, 4'h0, C_REL, 32'h0, "R5");
        op(K_WR, 1'b0, 4'h0, C_EN, 32'h0, "R5");
        op(K_WR, 1'b0, 4'h0, C_ZER, 32'h0, "R5");
        op(K_IDLE, 1'b0, 4'h0, 32'(NSAMP + 1), 32'h0, "R5");
        op(K_RD, 1'b1, 4'h4, 32'h0, 32'h57, "R5 second self-test passes");
        op(K_WR, 1'b0, 4'h0, C_ZAK, 32'h0, "R7");
        op(K_IDLE, 1'b0, 4'h0, 32'd1, 32'h0, "R7");
        op(K_RD, 1'b1, 4'h0, 32'h0, lfsr_word(NSAMP), "R5 reseeded first word");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule